// File: doc/BRIEF.md
# Interrupt Pending-State Register Bank

This block holds the pending state of a bank of interrupt sources (32 by default). Each source is set up as level-sensitive or edge-sensitive by a per-source configuration bit. Raw lines pass through a synchronizer first. Edge sources latch a pending bit on a rising edge. For level sources, pending is the live line combined with a software-pending latch. Because the line and the latch are kept apart, software can force or withdraw pending without hiding the wire, and a falling wire does not drop a pending state that software asked for.

Software reaches the bank through two write-one-to-act channels, one that sets pending and one that clears it. It reads the pending vector back from a read-data port. The CPU side reports which interrupt it has taken with an acknowledge strobe and reports completion with an end-of-interrupt strobe. Both strobes carry an interrupt ID. Priority, targeting and enables live elsewhere and consume the `pend` vector.

Top module: `irq_pend_bank`

## Requirements
- R1: For a source with `cfg_edge` bit 0 (level), `pend` is the synchronized line OR its software-pending latch.
- R2: A `set_we` cycle with `set_wdata` bit i = 1 makes `pend[i]` 1 at the next clock edge, for level and edge sources alike.
- R3: A set write loads the software-pending latch only for level sources. For an edge source (`cfg_edge` bit 1), a later acknowledge therefore clears pending without a latch holding it.
- R4: A `clr_we` cycle with `clr_wdata` bit i = 1 clears the latch of a level source, or the pending bit of an edge source. A level source whose line is still high stays pending.
- R5: A level source whose latch is set stays pending after its line drops.
- R6: `ack_vld` with `ack_id` = i clears the latch of level source i and the pending bit of edge source i at the next edge.
- R7: An edge source becomes pending on a rising edge of its synchronized line. A falling edge clears nothing.
- R8: `eoi_vld` with `eoi_id` = i on a level source clears its latch, so that source ends up pending exactly when its line is high. An end-of-interrupt strobe has no effect on an edge source.
- R9: `reg_rdata` always returns the current pending vector.
- R10: A set and a clear of the same bit in one cycle leave the bit pending and leave the latch set. A rising edge that coincides with an acknowledge leaves an edge source pending.
- R11: Reset (`rst_n` low, synchronous) clears all pending bits, latches and synchronizer stages.
- R12: A change on `irq_in` shows in `pend` at the third clock edge after it is applied: two synchronizer stages, then the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Raw interrupt lines |
| cfg_edge | input | NUM_SRC | Per-source trigger type: 0 level, 1 edge |
| set_we | input | 1 | Set-pending write strobe |
| set_wdata | input | NUM_SRC | Set-pending write data, one bit per source |
| clr_we | input | 1 | Clear-pending write strobe |
| clr_wdata | input | NUM_SRC | Clear-pending write data, one bit per source |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_id | input | ID_W | Acknowledged interrupt ID |
| eoi_vld | input | 1 | End-of-interrupt strobe |
| eoi_id | input | ID_W | Completed interrupt ID |
| pend | output | NUM_SRC | Pending vector |
| reg_rdata | output | NUM_SRC | Readback of the pending vector |

## Verification
The per-source assertions assume that `cfg_edge` for a source is steady around the cycles they look at. For that reason they only fire when the configuration was the same in the previous cycle. They also assume that the IDs on `ack_id` and `eoi_id` name existing sources. The stimulus sets the configuration once, with level on even sources and edge on odd ones, before reset is released, and it never changes it afterwards. Every ID it drives lies in range. Line changes are held for at least three cycles before `pend` is sampled, so the synchronizer latency is covered.

// File: rtl/irq_pend_pkg.sv
// Package: shared types for the interrupt pending bank.
// Assumes: nothing; holds only type definitions.
package irq_pend_pkg;

    // Trigger type as coded on the configuration bit.
    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_e;

    // Per-source command strobes decoded from the software and CPU ports.
    typedef struct packed {
        logic set;
        logic clr;
        logic ack;
        logic eoi;
    } cell_cmd_t;

endpackage

// File: rtl/irq_pend_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous lines.
// Assumes: each bit is independent; no multi-bit coherence is needed.
module irq_pend_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw lines.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d_in;
                end
            end else begin : g_next
                // Later stages shift the sample along.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/irq_pend_cell.sv
// Module: pending state of one interrupt source.
// Level sources: pending = synchronized line OR software latch.
// Edge sources: pending bit set on a rising edge or a set write; cleared
// by a clear write or an acknowledge. In every case a set wins over a clear.
// Assumes: lvl_s is already synchronized; cmd strobes last one cycle.
module irq_pend_cell
    import irq_pend_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl_s,
    input  trig_e     mode,
    input  cell_cmd_t cmd,
    output logic      pend_o
);
    logic lvl_d;
    logic soft_q;
    logic pend_q;
    logic soft_nx;
    logic pend_nx;
    logic rise;
    logic is_edge;

    assign is_edge = (mode == TRIG_EDGE);
    assign rise    = lvl_s & ~lvl_d;

    // Delay the synchronized line by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl_s;
    end

    // Next software latch: level only; clears applied first, set wins.
    always_comb begin
        if (is_edge)                          soft_nx = 1'b0;
        else if (cmd.set)                     soft_nx = 1'b1;
        else if (cmd.clr || cmd.ack || cmd.eoi) soft_nx = 1'b0;
        else                                  soft_nx = soft_q;
    end

    // Next pending state per trigger type.
    always_comb begin
        if (is_edge)
            pend_nx = rise | cmd.set | (pend_q & ~(cmd.clr | cmd.ack));
        else
            pend_nx = lvl_s | soft_nx;
    end

    // Register latch and pending bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            soft_q <= soft_nx;
            pend_q <= pend_nx;
        end
    end

    assign pend_o = pend_q;

    // A set latch on a level source forces pending.
    assert_latch_forces_pend_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_edge && $past(!is_edge) && soft_q) |-> pend_q);

    // A high line on a level source shows as pending next cycle.
    assert_line_forces_pend_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!is_edge && lvl_s) |-> pend_q);

    // A set write always results in pending.
    assert_set_pends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd.set) |-> pend_q);

    // A clear write without a set empties the latch.
    assert_clr_drops_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd.clr && !cmd.set) |-> !soft_q);

    // Acknowledge or end-of-interrupt without a set empties the latch.
    assert_ack_drops_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past((cmd.ack || cmd.eoi) && !cmd.set) |-> !soft_q);

    // An edge source stays pending unless cleared or acknowledged.
    assert_edge_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge && $past(is_edge && pend_q && !cmd.clr && !cmd.ack)) |-> pend_q);
endmodule

// File: rtl/irq_pend_bank.sv
// Module: top of the interrupt pending-state bank.
// Synchronizes the raw lines, decodes software writes and ack/EOI IDs into
// per-source strobes, and instantiates one pending cell per source.
// Assumes: cfg_edge is quasi-static; IDs outside the bank are ignored.
module irq_pend_bank
    import irq_pend_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int ID_W        = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] cfg_edge,
    input  logic               set_we,
    input  logic [NUM_SRC-1:0] set_wdata,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_wdata,
    input  logic               ack_vld,
    input  logic [ID_W-1:0]    ack_id,
    input  logic               eoi_vld,
    input  logic [ID_W-1:0]    eoi_id,
    output logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] reg_rdata
);
    localparam int ID_SPAN = 1 << ID_W;

    logic [NUM_SRC-1:0] lvl_sync;
    logic [NUM_SRC-1:0] ack_hot;
    logic [NUM_SRC-1:0] eoi_hot;

    irq_pend_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (irq_in),
        .q_out (lvl_sync)
    );

    // Decode acknowledge and EOI IDs into one-hot source strobes.
    always_comb begin
        ack_hot = '0;
        eoi_hot = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (k < ID_SPAN) begin
                ack_hot[k] = ack_vld && (ack_id == ID_W'(k));
                eoi_hot[k] = eoi_vld && (eoi_id == ID_W'(k));
            end
        end
    end

    genvar i;
    generate
        for (i = 0; i < NUM_SRC; i++) begin : g_src
            cell_cmd_t cmd;
            trig_e     mode;

            // Gather this source's strobes and trigger type.
            always_comb begin
                cmd.set = set_we && set_wdata[i];
                cmd.clr = clr_we && clr_wdata[i];
                cmd.ack = ack_hot[i];
                cmd.eoi = eoi_hot[i];
                mode    = cfg_edge[i] ? TRIG_EDGE : TRIG_LEVEL;
            end

            irq_pend_cell cell_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl_s  (lvl_sync[i]),
                .mode   (mode),
                .cmd    (cmd),
                .pend_o (pend[i])
            );
        end
    endgenerate

    assign reg_rdata = pend;

    // At most one source is acknowledged per cycle.
    assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_hot));

    // A bank-wide set write leaves every bit pending.
    assert_full_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set_we && (&set_wdata)) |-> (&pend));

    // Pending is empty in the first cycle after reset.
    assert_reset_empty_R11: assert property (@(posedge clk)
        $past(!rst_n) |-> (pend == '0));
endmodule

// File: tb/irq_pend_bank_tb_top.sv
module irq_pend_bank_tb_top;
    localparam int N  = 32;
    localparam int IW = 5;
    localparam logic [N-1:0] LVL = 32'h5555_5555;
    localparam logic [N-1:0] EDG = 32'hAAAA_AAAA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic [N-1:0]  cfg_edge = EDG;
    logic          set_we = 1'b0;
    logic [N-1:0]  set_wdata = '0;
    logic          clr_we = 1'b0;
    logic [N-1:0]  clr_wdata = '0;
    logic          ack_vld = 1'b0;
    logic [IW-1:0] ack_id = '0;
    logic          eoi_vld = 1'b0;
    logic [IW-1:0] eoi_id = '0;
    logic [N-1:0]  pend;
    logic [N-1:0]  reg_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_pend_bank dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_edge(cfg_edge),
        .set_we(set_we), .set_wdata(set_wdata), .clr_we(clr_we),
        .clr_wdata(clr_wdata), .ack_vld(ack_vld), .ack_id(ack_id),
        .eoi_vld(eoi_vld), .eoi_id(eoi_id), .pend(pend), .reg_rdata(reg_rdata)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [N-1:0] exp);
        checks++;
        if (pend !== exp) begin
            errors++;
            $display("FAIL %s pend actual=%h expected=%h", req, pend, exp);
        end
    endtask

    task automatic check_rd(input string req, input logic [N-1:0] exp);
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s rdata actual=%h expected=%h", req, reg_rdata, exp);
        end
    endtask

    task automatic wr_set(input logic [N-1:0] v);
        set_we = 1'b1; set_wdata = v; tick(1); set_we = 1'b0; set_wdata = '0;
    endtask

    task automatic wr_clr(input logic [N-1:0] v);
        clr_we = 1'b1; clr_wdata = v; tick(1); clr_we = 1'b0; clr_wdata = '0;
    endtask

    task automatic do_ack(input int id);
        ack_vld = 1'b1; ack_id = IW'(id); tick(1); ack_vld = 1'b0;
    endtask

    task automatic do_eoi(input int id);
        eoi_vld = 1'b1; eoi_id = IW'(id); tick(1); eoi_vld = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] exp;
        tick(4);
        check("R11 reset", '0);
        rst_n = 1'b1;
        tick(1);
        check("R11 after reset", '0);

        // Latency and live level / rising edge.
        irq_in = '1;
        tick(2);
        check("R12 not yet visible", '0);
        tick(1);
        check("R12 R1 R7 visible third edge", '1);
        check_rd("R9 readback", '1);
        irq_in = '0;
        tick(3);
        check("R1 R7 level drops edge holds", EDG);
        wr_clr('1);
        check("R4 clear edge pending", '0);

        // Set write then acknowledge, per source.
        for (int i = 0; i < N; i++) begin
            wr_set(N'(1) << i);
            check("R2 set single", N'(1) << i);
            do_ack(i);
            check("R3 R6 ack clears", '0);
        end

        // Latch holds level source across line drop.
        wr_set('1);
        check("R2 set all", '1);
        irq_in = '1; tick(3);
        irq_in = '0; tick(3);
        check("R5 latch holds after line drop", '1);
        wr_clr('1);
        check("R4 clear all lines low", '0);

        // Clear does not override a high line.
        irq_in = '1; tick(3);
        wr_clr('1);
        check("R4 high line stays pending", LVL);
        check_rd("R9 readback after clear", LVL);
        irq_in = '0; tick(3);
        check("R1 line low latch clear", '0);

        // EOI sweep with lines low.
        wr_set('1);
        exp = '1;
        for (int i = 0; i < N; i++) begin
            do_eoi(i);
            if (LVL[i]) exp[i] = 1'b0;
            check("R8 eoi line low", exp);
        end
        wr_clr('1);

        // EOI with lines high keeps level pending.
        irq_in = '1; tick(3);
        wr_set('1);
        for (int i = 0; i < N; i++) do_eoi(i);
        check("R8 eoi line high", '1);
        irq_in = '0; tick(3);
        check("R8 latch gone after eoi", EDG);
        wr_clr('1);
        check("R4 clear", '0);

        // Same-cycle set and clear.
        set_we = 1'b1; set_wdata = '1; clr_we = 1'b1; clr_wdata = '1;
        tick(1);
        set_we = 1'b0; clr_we = 1'b0;
        check("R10 set wins", '1);
        tick(2);
        check("R10 latch kept", '1);
        wr_clr('1);
        check("R10 cleanup", '0);

        // Ack coinciding with a rising edge on edge source 1.
        wr_set(32'h2);
        irq_in[1] = 1'b1;
        tick(2);
        do_ack(1);
        check("R10 rising edge beats ack", 32'h2);
        do_ack(1);
        check("R6 ack without edge clears", '0);
        irq_in[1] = 1'b0; tick(3);
        check("R7 falling edge no effect", '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule